// File: doc/BRIEF.md
# Single-Wire Addressed Register Slave

This block is the peripheral end of a single-wire serial bus on which several devices share the line and are told apart by a 4-bit identity. Pulse-width decoding happens upstream. The block sees a stream of pre-decoded symbols. Each symbol is a one-cycle strobe that carries either a 3-bit command code or a single data bit.

A host first runs an address sequence to pick one device. It may then write that device's data register or read it back. Reads are paced by prompts, and the register comes out one bit per prompt. An initialize sequence hands the device a new identity. The register length `DATA_W` is 8, 16 or 24 bits.

Each sequence opens with a command code, carries its bits least significant first, and is closed by the end code. Nothing is committed until the end code arrives, so an interrupted sequence leaves no trace.

Top module: `swire_reg_slave`

## Requirements
- R1: After reset, `reg_q` is 0, `selected` is 0, `rd_valid` is 0, and the device identity is the parameter `RESET_ID` (default 4'hA).
- R2: Command code 3'b010 opens an address sequence and drives `selected` low on the following cycle. When the end code 3'b111 arrives, `selected` rises one cycle later only if exactly 4 bits were received (first bit = identity bit 0) and they equal the device identity.
- R3: Command code 3'b001 opens a write sequence whose bits arrive LSB first. At the end code, if `selected` is set and at least `DATA_W` bits were received, `reg_q` takes the collected value one cycle later. With fewer bits `reg_q` is unchanged.
- R4: When a write carries more than `DATA_W` bits, `reg_q` takes the last `DATA_W` bits received, the earliest of them at bit 0.
- R5: Command code 3'b100 opens a read sequence. Each data-bit symbol inside it is a prompt. One cycle after a prompt, `rd_valid` pulses and `rd_bit` carries the next register bit, starting at bit 0.
- R6: After `DATA_W` prompts, read output wraps back to bit 0 of the register.
- R7: While `selected` is low, a write sequence leaves `reg_q` unchanged and read prompts produce no `rd_valid`.
- R8: Command code 3'b011 followed by exactly 4 bits (LSB first) and the end code makes those bits the device identity. Any other bit count leaves the identity unchanged.
- R9: An end code with no open sequence has no effect. Any command code received inside an open sequence abandons it and discards its partial bits.
- R10: Data bits outside any sequence are ignored. Undefined codes (3'b000, 3'b101, 3'b110) close the open sequence without committing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | One-cycle strobe marking a decoded symbol |
| sym_is_cmd | input | 1 | 1: symbol is a command code, 0: symbol is a data bit or prompt |
| sym_val | input | 3 | Command code, or data bit in bit 0 |
| reg_q | output | DATA_W | Committed data register |
| selected | output | 1 | Device chosen by the latest address sequence |
| rd_bit | output | 1 | Read data bit |
| rd_valid | output | 1 | One-cycle strobe qualifying `rd_bit` |

## Verification
Writes are tried with exactly `DATA_W` bits, with more than `DATA_W` bits, and with too few bits. These cases separate a correct last-N capture from a first-N capture and from a commit that skips the length check. Address sequences use a matching identity, a foreign identity, and a 3-bit or 5-bit field, which exposes compares that ignore the bit count. A long read run crosses the wrap point, and a read while deselected shows whether prompts are gated. Aborted writes, stray end codes, idle data bits and undefined codes show whether partial sequences can leak into the register. Initialize is followed by addressing both the new and the old identity, which shows the identity really moved.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;

   localparam int CODE_W = 3;

   typedef logic [CODE_W-1:0] code_t;

   localparam code_t CMD_WRITE = 3'b001;
   localparam code_t CMD_ADDR  = 3'b010;
   localparam code_t CMD_INIT  = 3'b011;
   localparam code_t CMD_READ  = 3'b100;
   localparam code_t CMD_END   = 3'b111;

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_ADDR  = 3'd1,
      SEQ_WRITE = 3'd2,
      SEQ_READ  = 3'd3,
      SEQ_INIT  = 3'd4
   } seq_t;

   // Sequence opened by a command code; end and undefined codes give idle.
   function automatic seq_t seq_for_code(input code_t c);
      case (c)
         CMD_WRITE: return SEQ_WRITE;
         CMD_ADDR:  return SEQ_ADDR;
         CMD_INIT:  return SEQ_INIT;
         CMD_READ:  return SEQ_READ;
         default:   return SEQ_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/swr_lsb_shift.sv
`timescale 1ns/1ps
// Shift register filled LSB first: each new bit enters at the top and
// moves down, so once W bits are in, the earliest of the last W is at bit 0.
module swr_lsb_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);

   logic [W-1:0] nxt;

   generate
      if (W < 1) begin : g_bad_w
         $error("swr_lsb_shift: W must be at least 1");
      end
      for (genvar g = 0; g < W; g++) begin : g_bit
         if (g == W - 1) begin : g_top
            assign nxt[g] = din;
         end else begin : g_mid
            assign nxt[g] = q[g+1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clear) begin
         q <= '0;
      end else if (shift_en) begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/swr_seq_ctrl.sv
`timescale 1ns/1ps
module swr_seq_ctrl
   import swr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ID_W   = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sym_valid,
   input  logic  sym_is_cmd,
   input  code_t sym_val,
   output seq_t  seq_q,
   output logic  seq_open,
   output logic  read_open,
   output logic  addr_open,
   output logic  bit_take,
   output logic  addr_commit,
   output logic  init_commit,
   output logic  write_commit
);

   localparam int CNT_MAX = DATA_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] CNT_ID   = CNT_W'(ID_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (ID_W > DATA_W) begin : g_bad_id
         $error("swr_seq_ctrl: ID_W must not exceed DATA_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             cmd_stb;
   logic             bit_stb;
   logic             end_stb;
   seq_t             next_seq;

   assign cmd_stb  = sym_valid & sym_is_cmd;
   assign bit_stb  = sym_valid & ~sym_is_cmd;
   assign end_stb  = cmd_stb && (sym_val == CMD_END);
   assign next_seq = seq_for_code(sym_val);

   // Any command code restarts the field count; the end code and undefined
   // codes return to idle, which discards whatever the shadows held.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= SEQ_IDLE;
         cnt_q <= '0;
      end else if (cmd_stb) begin
         seq_q <= end_stb ? SEQ_IDLE : next_seq;
         cnt_q <= '0;
      end else if (bit_take && cnt_q != CNT_TOP) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   always_comb begin
      seq_open     = cmd_stb && !end_stb && (next_seq != SEQ_IDLE);
      read_open    = cmd_stb && (sym_val == CMD_READ);
      addr_open    = cmd_stb && (sym_val == CMD_ADDR);
      bit_take     = bit_stb && (seq_q != SEQ_IDLE);
      addr_commit  = end_stb && (seq_q == SEQ_ADDR)  && (cnt_q == CNT_ID);
      init_commit  = end_stb && (seq_q == SEQ_INIT)  && (cnt_q == CNT_ID);
      write_commit = end_stb && (seq_q == SEQ_WRITE) && (cnt_q >= CNT_FULL);
   end

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_TOP); // R4

   AST_END_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      end_stb |=> seq_q == SEQ_IDLE); // R9

   AST_IDLE_HOLDS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      seq_q == SEQ_IDLE |-> cnt_q == '0); // R10

endmodule

// File: rtl/swr_read_port.sv
`timescale 1ns/1ps
// Serialises the committed register, one bit per prompt, LSB first, wrapping.
// ROTATE = 0: pointer into the live register; ROTATE = 1: rotating snapshot.
module swr_read_port #(
   parameter int DATA_W = 8,
   parameter bit ROTATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              prompt,
   input  logic [DATA_W-1:0] word,
   output logic              rd_bit,
   output logic              rd_valid
);

   localparam int PTR_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DATA_W - 1);
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= prompt;
      end
   end

   generate
      if (ROTATE) begin : g_rotate
         logic [DATA_W-1:0] rot_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rot_q  <= '0;
               rd_bit <= 1'b0;
            end else if (load) begin
               rot_q <= word;
            end else if (prompt) begin
               rd_bit <= rot_q[0];
               rot_q  <= {rot_q[0], rot_q[DATA_W-1:1]};
            end
         end

         AST_ROT_KEEPS_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            (prompt && !load) |=> $countones(rot_q) == $past($countones(rot_q))); // R6

      end else begin : g_index
         logic [PTR_W-1:0] ptr_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr_q  <= '0;
               rd_bit <= 1'b0;
            end else if (load) begin
               ptr_q <= '0;
            end else if (prompt) begin
               rd_bit <= word[ptr_q];
               ptr_q  <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_ONE;
            end
         end

         AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ptr_q <= PTR_LAST); // R6

         AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
            (prompt && !load && ptr_q == PTR_LAST) |=> ptr_q == '0); // R6
      end
   endgenerate

endmodule

// File: rtl/swire_reg_slave.sv
`timescale 1ns/1ps
module swire_reg_slave
   import swr_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          ID_W        = 4,
   parameter int unsigned RESET_ID    = 10,
   parameter bit          READ_ROTATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_valid,
   input  logic              sym_is_cmd,
   input  logic [2:0]        sym_val,
   output logic [DATA_W-1:0] reg_q,
   output logic              selected,
   output logic              rd_bit,
   output logic              rd_valid
);

   localparam logic [ID_W-1:0] ID_AT_RESET = ID_W'(RESET_ID);

   generate
      if (DATA_W != 8 && DATA_W != 16 && DATA_W != 24) begin : g_bad_data_w
         $error("swire_reg_slave: DATA_W must be 8, 16 or 24");
      end
      if (ID_W != 4) begin : g_bad_id_w
         $error("swire_reg_slave: ID_W must be 4");
      end
   endgenerate

   seq_t              seq_q;
   logic              seq_open;
   logic              read_open;
   logic              addr_open;
   logic              bit_take;
   logic              addr_commit;
   logic              init_commit;
   logic              write_commit;
   logic [ID_W-1:0]   id_shadow;
   logic [DATA_W-1:0] data_shadow;
   logic [ID_W-1:0]   dev_id_q;
   logic              end_seen;
   logic              id_shift;
   logic              data_shift;
   logic              prompt;

   swr_seq_ctrl #(
      .DATA_W (DATA_W),
      .ID_W   (ID_W)
   ) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sym_valid    (sym_valid),
      .sym_is_cmd   (sym_is_cmd),
      .sym_val      (sym_val),
      .seq_q        (seq_q),
      .seq_open     (seq_open),
      .read_open    (read_open),
      .addr_open    (addr_open),
      .bit_take     (bit_take),
      .addr_commit  (addr_commit),
      .init_commit  (init_commit),
      .write_commit (write_commit)
   );

   assign id_shift   = bit_take && (seq_q == SEQ_ADDR || seq_q == SEQ_INIT);
   assign data_shift = bit_take && (seq_q == SEQ_WRITE);
   assign prompt     = bit_take && (seq_q == SEQ_READ) && selected;
   assign end_seen   = sym_valid && sym_is_cmd && (sym_val == CMD_END);

   swr_lsb_shift #(.W(ID_W)) i_id_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (seq_open),
      .shift_en (id_shift),
      .din      (sym_val[0]),
      .q        (id_shadow)
   );

   swr_lsb_shift #(.W(DATA_W)) i_data_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (seq_open),
      .shift_en (data_shift),
      .din      (sym_val[0]),
      .q        (data_shadow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_id_q <= ID_AT_RESET;
      end else if (init_commit) begin
         dev_id_q <= id_shadow;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         selected <= 1'b0;
      end else if (addr_open) begin
         selected <= 1'b0;
      end else if (addr_commit) begin
         selected <= (id_shadow == dev_id_q);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (write_commit && selected) begin
         reg_q <= data_shadow;
      end
   end

   swr_read_port #(
      .DATA_W (DATA_W),
      .ROTATE (READ_ROTATE)
   ) i_read (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (read_open),
      .prompt   (prompt),
      .word     (reg_q),
      .rd_bit   (rd_bit),
      .rd_valid (rd_valid)
   );

   AST_SEL_DROPS_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_is_cmd && sym_val == CMD_ADDR) |=> !selected); // R2

   AST_SEL_RISES_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected) |-> $past(end_seen)); // R2

   AST_REG_ONLY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_q) |-> $past(end_seen && selected)); // R3

   AST_ID_ONLY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_id_q) |-> $past(end_seen)); // R8

   AST_READ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> selected && $past(sym_valid && !sym_is_cmd)); // R7

endmodule

// File: tb/test_swire_reg_slave.sv
`timescale 1ns/1ps
module test_swire_reg_slave;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sym_valid = 1'b0;
   logic         sym_is_cmd = 1'b0;
   logic [2:0]   sym_val = 3'b000;
   logic [N-1:0] reg_q;
   logic         selected;
   logic         rd_bit;
   logic         rd_valid;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   swire_reg_slave #(.DATA_W(N), .ID_W(4), .RESET_ID(10), .READ_ROTATE(1'b0)) i_swire_reg_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .sym_valid  (sym_valid),
      .sym_is_cmd (sym_is_cmd),
      .sym_val    (sym_val),
      .reg_q      (reg_q),
      .selected   (selected),
      .rd_bit     (rd_bit),
      .rd_valid   (rd_valid)
   );

   // ---------------- behavioural reference ----------------
   logic [N-1:0] m_reg;
   bit           m_sel;
   bit   [3:0]   m_id;
   int           m_state;      // 0 idle, 1 addr, 2 write, 3 read, 4 init
   int           m_cnt;
   bit   [3:0]   m_abits;
   bit           m_q[$];
   bit           m_rdv;
   bit           m_rdb;
   int           m_ptr;

   always @(posedge clk) begin
      m_rdv = 1'b0;
      if (!rst_n) begin
         m_reg = '0; m_sel = 0; m_id = 4'hA; m_state = 0; m_cnt = 0;
         m_abits = 0; m_q.delete(); m_ptr = 0;
      end else if (sym_valid && sym_is_cmd) begin
         if (sym_val == 3'b111) begin
            if (m_state == 1) m_sel = (m_cnt == 4) && (m_abits == m_id);
            if (m_state == 2 && m_sel && m_q.size() >= N)
               for (int i = 0; i < N; i++) m_reg[i] = m_q[m_q.size() - N + i];
            if (m_state == 4 && m_cnt == 4) m_id = m_abits;
            m_state = 0;
         end else begin
            case (sym_val)
               3'b001: m_state = 2;
               3'b010: begin m_state = 1; m_sel = 0; end
               3'b011: m_state = 4;
               3'b100: m_state = 3;
               default: m_state = 0;
            endcase
            m_cnt = 0; m_abits = 0; m_q.delete(); m_ptr = 0;
         end
      end else if (sym_valid) begin
         case (m_state)
            1, 4: begin
               if (m_cnt < 4) m_abits[m_cnt] = sym_val[0];
               m_cnt++;
            end
            2: m_q.push_back(sym_val[0]);
            3: if (m_sel) begin
               m_rdv = 1'b1;
               m_rdb = m_reg[m_ptr];
               m_ptr = (m_ptr + 1) % N;
            end
            default: ;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the reference.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_req, " reg_q"}, 32'(reg_q), 32'(m_reg));
         chk({cur_req, " selected"}, 32'(selected), 32'(m_sel));
         chk({cur_req, " rd_valid"}, 32'(rd_valid), 32'(m_rdv));
         if (m_rdv) chk({cur_req, " rd_bit"}, 32'(rd_bit), 32'(m_rdb));
      end
   end

   // ---------------- stimulus ----------------
   task automatic sym(input bit is_cmd, input logic [2:0] v);
      @(negedge clk);
      sym_valid = 1'b1; sym_is_cmd = is_cmd; sym_val = v;
      @(negedge clk);
      sym_valid = 1'b0; sym_is_cmd = 1'b0; sym_val = 3'b000;
   endtask

   task automatic bits(input logic [63:0] v, input int n);
      for (int i = 0; i < n; i++) sym(1'b0, {2'b00, v[i]});
   endtask

   task automatic do_addr(input logic [3:0] id, input int n);
      sym(1'b1, 3'b010); bits(64'(id), n); sym(1'b1, 3'b111);
   endtask

   task automatic do_init(input logic [3:0] id, input int n);
      sym(1'b1, 3'b011); bits(64'(id), n); sym(1'b1, 3'b111);
   endtask

   task automatic do_write(input logic [63:0] v, input int n);
      sym(1'b1, 3'b001); bits(v, n); sym(1'b1, 3'b111);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [N-1:0] word;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 reset reg_q", 32'(reg_q), 32'h0);
      chk("R1 reset selected", 32'(selected), 32'h0);
      chk("R1 reset rd_valid", 32'(rd_valid), 32'h0);
      do_addr(4'hA, 4);
      chk("R1 reset id selects", 32'(selected), 32'h1);

      cur_req = "R3";
      do_write(64'h3C, 8);
      chk("R3 exact write", 32'(reg_q), 32'h3C);

      cur_req = "R4";
      do_write(64'h5A7, 11);
      chk("R4 last N kept", 32'(reg_q), 32'((64'h5A7 >> 3) & 64'hFF));

      cur_req = "R3";
      do_write(64'h0F, 5);
      chk("R3 short write ignored", 32'(reg_q), 32'hB4);

      cur_req = "R5";
      word = reg_q;
      sym(1'b1, 3'b100);
      for (int i = 0; i < 20; i++) begin
         if (i >= N) cur_req = "R6";
         sym(1'b0, 3'b000);
         chk((i < N) ? "R5 read valid" : "R6 wrap valid", 32'(rd_valid), 32'h1);
         chk((i < N) ? "R5 read bit" : "R6 wrap bit", 32'(rd_bit), 32'(word[i % N]));
      end
      sym(1'b1, 3'b111);

      cur_req = "R2";
      sym(1'b1, 3'b010);
      chk("R2 address code drops select", 32'(selected), 32'h0);
      bits(64'h3, 4); sym(1'b1, 3'b111);
      chk("R2 foreign id", 32'(selected), 32'h0);

      cur_req = "R7";
      do_write(64'h11, 8);
      chk("R7 deselected write", 32'(reg_q), 32'hB4);
      sym(1'b1, 3'b100);
      for (int i = 0; i < 3; i++) begin
         sym(1'b0, 3'b001);
         chk("R7 deselected read", 32'(rd_valid), 32'h0);
      end
      sym(1'b1, 3'b111);

      cur_req = "R8";
      do_init(4'h3, 4);
      do_addr(4'h3, 4);
      chk("R8 new id selects", 32'(selected), 32'h1);
      do_addr(4'hA, 4);
      chk("R8 old id rejected", 32'(selected), 32'h0);
      do_init(4'h7, 3);
      do_addr(4'h3, 4);
      chk("R8 short init ignored", 32'(selected), 32'h1);

      cur_req = "R9";
      sym(1'b1, 3'b111);
      chk("R9 stray end", 32'(selected), 32'h1);
      sym(1'b1, 3'b001); bits(64'h3FF, 10);
      sym(1'b1, 3'b010); bits(64'h3, 4); sym(1'b1, 3'b111);
      chk("R9 aborted write reg", 32'(reg_q), 32'hB4);
      chk("R9 aborted write sel", 32'(selected), 32'h1);
      sym(1'b1, 3'b111);
      chk("R9 second stray end", 32'(reg_q), 32'hB4);

      cur_req = "R10";
      bits(64'hFF, 6);
      do_write(64'h66, 8);
      chk("R10 idle bits ignored", 32'(reg_q), 32'h66);
      sym(1'b1, 3'b001); bits(64'h99, 8);
      sym(1'b1, 3'b101); sym(1'b1, 3'b111);
      chk("R10 undefined code aborts", 32'(reg_q), 32'h66);

      cur_req = "R2";
      do_addr(4'h3, 3);
      chk("R2 short address", 32'(selected), 32'h0);
      do_addr(4'h3, 5);
      chk("R2 long address", 32'(selected), 32'h0);
      do_addr(4'h3, 4);
      chk("R2 reselect", 32'(selected), 32'h1);

      cur_req = "R4";
      do_write(64'hABCDE, 20);
      chk("R4 long write", 32'(reg_q), 32'((64'hABCDE >> 12) & 64'hFF));

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule